// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a small bank of system configuration registers reached over a plain synchronous register bus. Writes to the configuration registers are refused until software performs an unlock handshake: one key value goes to a first kick register, then a second key value goes to a second kick register. A stray value in either kick register closes the bank again. The device-state control register also needs a separate lock register to hold its own key value. While the bank is closed, a write to a protected register is dropped and raises a one-cycle error flag.

The protected contents have three kinds of write behaviour:

- **Device-state fields.** The device-state control register holds a row of 2-bit fields. Each field accepts only its legal enable or disable code. Its top field cannot be disabled once it has been enabled.
- **Keep-on register.** Each bit is set by writing 1. Writing 0 does not clear it, so an enabled device cannot be turned off.
- **Write-once register.** It takes the first write that is accepted and holds that value until reset.

A read-only device status word and a silicon revision nibble can also be read. Reads are never blocked.

The bus carries register accesses, not a data stream. For that reason it has no valid/ready handshake. A write is one cycle with `bus_we` high. A read is a combinational lookup of `bus_addr`. The bus never applies back-pressure.

Top module: `cfgbank_top`

## Requirements
- R1: After reset, the following all read 0: the kick state (read at 0x38), the lock register (0x40004), the device-state register (0x40008), the write-once register (0x40010) and the keep-on register (0x4002C). `bank_open_o` and `bus_wr_err` are also 0.
- R2: The kick state reads as 0 = locked, 1 = first key seen, 2 = open. Writing 0x83E70B13 to 0x38 moves it to 1. A following write of 0x95A4F1E0 to 0x3C moves it to 2 and raises `bank_open_o`.
- R3: A correct second key written to 0x3C when the state is not 1 leaves the state at 0. Keys written in reversed order therefore do not open the bank.
- R4: Writing any other value to 0x38 or 0x3C returns the state to 0, including from the open state.
- R5: A write to 0x40008, 0x40010 or 0x4002C while the bank is not open changes nothing. `bus_wr_err` is then high for exactly the one cycle after that write.
- R6: The lock register at 0x40004 can be written and read back in any state. A write to 0x40008 is accepted only when the bank is open and the lock register holds 0x0F0A0B00. Otherwise the write is dropped with an error pulse.
- R7: Register 0x40008 holds twelve 2-bit fields at bits 23:0, with field k at bits 2k+1:2k. Each field stores only code 1 (enable) or code 0 (disable), and any other code leaves it unchanged. Bits 29:24 read as 0.
- R8: The field at bits 31:30 stores only code 3 (enable) or code 0. Once it holds 3, it keeps 3 until reset.
- R9: Register 0x4002C has eight 1-bit fields at bits 7:0. A 1 sets a field and a 0 is ignored, so a field is cleared only by reset. Bits 31:8 read as 0.
- R10: Register 0x40010 stores the first accepted write. Later accepted writes are ignored and raise no error. Reset makes it writable again.
- R11: Reads are permitted in every lock state:
  - 0x00 returns `dev_status_i`.
  - 0x08 returns the revision in bits 31:28, with 0 below.
  - Unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 20 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| bus_wr_err | output | 1 | One-cycle pulse after a dropped protected write |
| dev_status_i | input | 32 | Device status word shown at 0x00 |
| dev_ctl_o | output | 32 | Contents of the device-state register |
| dev_keep_on_o | output | 8 | Keep-on enable bits |
| once_cfg_o | output | 32 | Contents of the write-once register |
| bank_open_o | output | 1 | High while the kick handshake is complete |

## Verification
The assertions assume the following about the bus:
- `bus_we`, `bus_addr` and `bus_wdata` are known (not X) at every clock edge after reset.
- A write lasts exactly one cycle, so the cycle after a write is judged against the value held before it.

The bench meets these assumptions as follows:
- It changes bus inputs only on the falling edge.
- It drops `bus_we` one cycle after raising it.
- It leaves the address and data at defined values between accesses.
- It applies reset only on a falling edge.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_STATUS = 20'h00000;
  localparam logic [ADDR_W-1:0] A_REV    = 20'h00008;
  localparam logic [ADDR_W-1:0] A_KICK0  = 20'h00038;
  localparam logic [ADDR_W-1:0] A_KICK1  = 20'h0003C;
  localparam logic [ADDR_W-1:0] A_LOCK   = 20'h40004;
  localparam logic [ADDR_W-1:0] A_DEVCTL = 20'h40008;
  localparam logic [ADDR_W-1:0] A_ONCE   = 20'h40010;
  localparam logic [ADDR_W-1:0] A_KEEPON = 20'h4002C;

  localparam logic [DATA_W-1:0] KICK_KEY0 = 32'h83E70B13;
  localparam logic [DATA_W-1:0] KICK_KEY1 = 32'h95A4F1E0;
  localparam logic [DATA_W-1:0] LOCK_KEY  = 32'h0F0A0B00;

  localparam logic [1:0] CODE_OFF   = 2'd0;
  localparam logic [1:0] CODE_ON_LO = 2'd1;
  localparam logic [1:0] CODE_ON_HI = 2'd3;

  localparam int WP_PLAIN  = 0;
  localparam int WP_ONCE   = 1;
  localparam int WP_STICKY = 2;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } kick_state_e;
endpackage

// File: rtl/cfgbank_kick.sv
module cfgbank_kick
  import cfgbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_k0,
  input  logic              wr_k1,
  input  logic [DATA_W-1:0] wdata,
  output kick_state_e       state_o,
  output logic              open_o
);
  kick_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_k0)
      state_d = (wdata == KICK_KEY0) ? KS_HALF : KS_LOCKED;
    else if (wr_k1)
      state_d = (wdata == KICK_KEY1 && state_q == KS_HALF) ? KS_OPEN : KS_LOCKED;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign open_o  = (state_q == KS_OPEN);

  // R2 / R3: the open state is only ever entered straight from the half state
  p_open_from_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_OPEN && $past(state_q) != KS_OPEN) |-> ($past(state_q) == KS_HALF && $past(wr_k1)));

  // R4: a wrong key in either kick register relocks
  p_bad_key_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_k0 && wdata != KICK_KEY0) || (wr_k1 && wdata != KICK_KEY1)) |=> state_q == KS_LOCKED);
endmodule

// File: rtl/cfgbank_wpreg.sv
module cfgbank_wpreg
  import cfgbank_pkg::*;
#(
  parameter int W    = 32,
  parameter int MODE = WP_PLAIN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  generate
    if (MODE == WP_ONCE) begin : g_once
      logic done_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q      <= '0;
          done_q <= 1'b0;
        end else if (wr_en && !done_q) begin
          q      <= wdata;
          done_q <= 1'b1;
        end
      end
      // R10: once the first write is taken the contents never move
      p_once_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done_q) |-> $stable(q));
    end else if (MODE == WP_STICKY) begin : g_sticky
      always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= q | wdata;
      end
      // R9: no set bit ever clears outside reset
      p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q) & ~q) == '0);
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/cfgbank_devctl.sv
module cfgbank_devctl
  import cfgbank_pkg::*;
#(
  parameter int N_FIELDS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_o
);
  localparam int LO_BITS = 2 * N_FIELDS;

  logic [1:0] fld_q [N_FIELDS];
  logic [1:0] hi_q;
  logic [1:0] hi_code;
  logic       unused_rsvd;

  assign unused_rsvd = ^wdata[29:LO_BITS];
  assign hi_code     = wdata[31:30];

  genvar f;
  generate
    for (f = 0; f < N_FIELDS; f++) begin : g_fld
      logic [1:0] code;
      assign code = wdata[2*f +: 2];
      always_ff @(posedge clk) begin
        if (!rst_n)
          fld_q[f] <= CODE_OFF;
        else if (wr_en && (code == CODE_ON_LO || code == CODE_OFF))
          fld_q[f] <= code;
      end
      // R7: a field only ever holds a legal code
      p_field_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_q[f] == CODE_OFF || fld_q[f] == CODE_ON_LO));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)
      hi_q <= CODE_OFF;
    else if (wr_en && hi_q != CODE_ON_HI && (hi_code == CODE_ON_HI || hi_code == CODE_OFF))
      hi_q <= hi_code;
  end

  // R8: the top field stays enabled once enabled
  p_hi_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hi_q) == CODE_ON_HI) |-> (hi_q == CODE_ON_HI));

  always_comb begin
    ctl_o = '0;
    for (int i = 0; i < N_FIELDS; i++) ctl_o[2*i +: 2] = fld_q[i];
    ctl_o[31:30] = hi_q;
  end
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int         STICKY_N = 8,
  parameter int         N_FIELDS = 12,
  parameter logic [3:0] REV      = 4'h2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_wr_err,
  input  logic [DATA_W-1:0]   dev_status_i,
  output logic [DATA_W-1:0]   dev_ctl_o,
  output logic [STICKY_N-1:0] dev_keep_on_o,
  output logic [DATA_W-1:0]   once_cfg_o,
  output logic                bank_open_o
);
  localparam int PAD_W = DATA_W - STICKY_N;

  kick_state_e       kick_state;
  logic [DATA_W-1:0] lock_q;
  logic              hit_ctl, hit_once, hit_keep;
  logic              ctl_ok, wr_ctl, wr_once, wr_keep, drop, err_q;

  assign hit_ctl  = bus_we && (bus_addr == A_DEVCTL);
  assign hit_once = bus_we && (bus_addr == A_ONCE);
  assign hit_keep = bus_we && (bus_addr == A_KEEPON);

  assign ctl_ok  = bank_open_o && (lock_q == LOCK_KEY);
  assign wr_ctl  = hit_ctl && ctl_ok;
  assign wr_once = hit_once && bank_open_o;
  assign wr_keep = hit_keep && bank_open_o;
  assign drop    = (hit_ctl && !ctl_ok) || ((hit_once || hit_keep) && !bank_open_o);

  cfgbank_kick u_kick (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_k0   (bus_we && bus_addr == A_KICK0),
    .wr_k1   (bus_we && bus_addr == A_KICK1),
    .wdata   (bus_wdata),
    .state_o (kick_state),
    .open_o  (bank_open_o)
  );

  cfgbank_wpreg #(.W(DATA_W), .MODE(WP_PLAIN)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_we && bus_addr == A_LOCK),
    .wdata (bus_wdata),
    .q     (lock_q)
  );

  cfgbank_wpreg #(.W(DATA_W), .MODE(WP_ONCE)) u_once (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_once),
    .wdata (bus_wdata),
    .q     (once_cfg_o)
  );

  cfgbank_wpreg #(.W(STICKY_N), .MODE(WP_STICKY)) u_keep (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_keep),
    .wdata (bus_wdata[STICKY_N-1:0]),
    .q     (dev_keep_on_o)
  );

  cfgbank_devctl #(.N_FIELDS(N_FIELDS)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_ctl),
    .wdata (bus_wdata),
    .ctl_o (dev_ctl_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= drop;
  end
  assign bus_wr_err = err_q;

  always_comb begin
    case (bus_addr)
      A_STATUS: bus_rdata = dev_status_i;
      A_REV:    bus_rdata = {REV, 28'd0};
      A_KICK0:  bus_rdata = {30'd0, kick_state};
      A_LOCK:   bus_rdata = lock_q;
      A_DEVCTL: bus_rdata = dev_ctl_o;
      A_ONCE:   bus_rdata = once_cfg_o;
      A_KEEPON: bus_rdata = {{PAD_W{1'b0}}, dev_keep_on_o};
      default:  bus_rdata = '0;
    endcase
  end

  // R5: a keep-on write while closed changes nothing and flags an error
  p_closed_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_keep && !bank_open_o) |=> (bus_wr_err && $stable(dev_keep_on_o)));

  // R6: a control write without the lock key is refused and flagged
  p_lock_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ctl && lock_q != LOCK_KEY) |=> (bus_wr_err && $stable(dev_ctl_o)));

  // R10: write-once register never raises the error flag while open
  p_once_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_once && bank_open_o && !hit_ctl) |=> !bus_wr_err);
endmodule

// File: tb/sim_cfgbank_top.sv
module sim_cfgbank_top;
  import cfgbank_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_wr_err;
  logic [DATA_W-1:0] dev_status_i = 32'h12345678;
  logic [DATA_W-1:0] dev_ctl_o;
  logic [7:0]        dev_keep_on_o;
  logic [DATA_W-1:0] once_cfg_o;
  logic              bank_open_o;

  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;

  cfgbank_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wr_err(bus_wr_err),
    .dev_status_i(dev_status_i), .dev_ctl_o(dev_ctl_o),
    .dev_keep_on_o(dev_keep_on_o), .once_cfg_o(once_cfg_o),
    .bank_open_o(bank_open_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, output logic err);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    err = bus_wr_err;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset_state;
    logic [31:0] d;
    rd(A_KICK0, d);  chk("R1 kick state", d, 0);
    rd(A_LOCK, d);   chk("R1 lock reg", d, 0);
    rd(A_DEVCTL, d); chk("R1 devctl", d, 0);
    rd(A_ONCE, d);   chk("R1 once reg", d, 0);
    rd(A_KEEPON, d); chk("R1 keep-on", d, 0);
    chk("R1 open flag", {31'd0, bank_open_o}, 0);
    chk("R1 err flag", {31'd0, bus_wr_err}, 0);
  endtask

  task automatic t_reads;
    logic [31:0] d;
    rd(A_STATUS, d); chk("R11 status", d, 32'h12345678);
    rd(A_REV, d);    chk("R11 revision", d, 32'h20000000);
    rd(20'h00100, d); chk("R11 unmapped", d, 0);
  endtask

  task automatic t_locked_drop;
    logic e; logic [31:0] d;
    wr(A_KEEPON, 32'h1, e); chk("R5 err pulse", {31'd0, e}, 1);
    @(negedge clk); chk("R5 err one cycle", {31'd0, bus_wr_err}, 0);
    chk("R5 keep-on untouched", {24'd0, dev_keep_on_o}, 0);
    wr(A_ONCE, 32'hDEAD, e); chk("R5 once err", {31'd0, e}, 1);
    rd(A_ONCE, d); chk("R5 once untouched", d, 0);
  endtask

  task automatic t_reverse;
    logic e; logic [31:0] d;
    wr(A_KICK1, KICK_KEY1, e); rd(A_KICK0, d); chk("R3 key1 first stays locked", d, 0);
    wr(A_KICK0, KICK_KEY0, e); rd(A_KICK0, d); chk("R3 reversed half only", d, 1);
    chk("R3 not open", {31'd0, bank_open_o}, 0);
    wr(A_KEEPON, 32'h1, e); chk("R3 write still refused", {31'd0, e}, 1);
    wr(A_KICK1, 32'h0, e); rd(A_KICK0, d); chk("R4 bad key1 relocks", d, 0);
  endtask

  task automatic t_wrong_key;
    logic e; logic [31:0] d;
    wr(A_KICK0, KICK_KEY0, e); wr(A_KICK0, 32'h1234, e);
    rd(A_KICK0, d); chk("R4 bad key0 relocks", d, 0);
    wr(A_KICK1, KICK_KEY1, e); rd(A_KICK0, d); chk("R4 key1 after bad key0", d, 0);
  endtask

  task automatic t_order;
    logic e; logic [31:0] d;
    wr(A_KICK0, KICK_KEY0, e); rd(A_KICK0, d); chk("R2 first key", d, 1);
    wr(A_KICK1, KICK_KEY1, e); rd(A_KICK0, d); chk("R2 second key", d, 2);
    chk("R2 open flag", {31'd0, bank_open_o}, 1);
  endtask

  task automatic t_lock;
    logic e; logic [31:0] d;
    wr(A_DEVCTL, 32'h1, e); chk("R6 no lock key err", {31'd0, e}, 1);
    rd(A_DEVCTL, d); chk("R6 no lock key drop", d, 0);
    wr(A_LOCK, LOCK_KEY, e); rd(A_LOCK, d); chk("R6 lock readback", d, LOCK_KEY);
    wr(A_DEVCTL, 32'h5, e); chk("R6 accepted no err", {31'd0, e}, 0);
    rd(A_DEVCTL, d); chk("R6 accepted value", d, 32'h5);
  endtask

  task automatic t_fields;
    logic e; logic [31:0] d;
    wr(A_DEVCTL, 32'h3F000036, e); rd(A_DEVCTL, d); chk("R7 illegal codes kept", d, 32'h5);
    wr(A_DEVCTL, 32'h0, e); rd(A_DEVCTL, d); chk("R7 disable all", d, 0);
    wr(A_DEVCTL, 32'h00555555, e); rd(A_DEVCTL, d); chk("R7 enable all", d, 32'h00555555);
    wr(A_DEVCTL, 32'h0, e);
  endtask

  task automatic t_hi;
    logic e; logic [31:0] d;
    wr(A_DEVCTL, 32'h40000000, e); rd(A_DEVCTL, d); chk("R8 illegal hi code", d, 0);
    wr(A_DEVCTL, 32'hC0000001, e); rd(A_DEVCTL, d); chk("R8 hi enable", d, 32'hC0000001);
    wr(A_DEVCTL, 32'h0, e); rd(A_DEVCTL, d); chk("R8 hi cannot disable", d, 32'hC0000000);
  endtask

  task automatic t_sticky;
    logic e; logic [31:0] d;
    wr(A_KEEPON, 32'h3, e); chk("R9 set", {24'd0, dev_keep_on_o}, 32'h3);
    wr(A_KEEPON, 32'h0, e); chk("R9 zero ignored", {24'd0, dev_keep_on_o}, 32'h3);
    wr(A_KEEPON, 32'hFFFFFF04, e); rd(A_KEEPON, d); chk("R9 accumulate and pad", d, 32'h7);
  endtask

  task automatic t_once;
    logic e; logic [31:0] d;
    wr(A_ONCE, 32'hA5A5A5A5, e); rd(A_ONCE, d); chk("R10 first write", d, 32'hA5A5A5A5);
    wr(A_ONCE, 32'h12345678, e); chk("R10 no err", {31'd0, e}, 0);
    rd(A_ONCE, d); chk("R10 second ignored", d, 32'hA5A5A5A5);
  endtask

  task automatic t_relock;
    logic e; logic [31:0] d;
    wr(A_LOCK, 32'h0, e); wr(A_DEVCTL, 32'h1, e); chk("R6 relocked err", {31'd0, e}, 1);
    rd(A_DEVCTL, d); chk("R6 relocked value", d, 32'hC0000000);
    wr(A_KICK0, 32'h0, e); rd(A_KICK0, d); chk("R4 open relocks", d, 0);
    chk("R4 open flag low", {31'd0, bank_open_o}, 0);
    rd(A_STATUS, d); chk("R11 read while locked", d, 32'h12345678);
  endtask

  task automatic t_reset_clear;
    logic e; logic [31:0] d;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    wr(A_KICK0, KICK_KEY0, e); wr(A_KICK1, KICK_KEY1, e);
    wr(A_ONCE, 32'h11, e); rd(A_ONCE, d); chk("R10 writable after reset", d, 32'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_reads();
    t_locked_drop();
    t_reverse();
    t_wrong_key();
    t_order();
    t_lock();
    t_fields();
    t_hi();
    t_sticky();
    t_once();
    t_relock();
    t_reset_clear();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL R1 watchdog got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule